// File: doc/BRIEF.md
# Pipelined Control Word Decoder

The block sits beside the decode stage of a five-stage in-order processor. It looks at the 6-bit opcode of the instruction being decoded. From it, it produces one complete set of control bits, split into three groups: one for execute, one for memory access and one for write-back.

The three groups are captured together into the decode/execute control register. As the instruction advances, each group moves into the next stage register. The execute group stops at decode/execute. The memory group stops at execute/memory. Only the write-back group reaches memory/write-back. Each group is therefore used one, two or three cycles after it was produced.

A bubble input loads an all-zero word into the decode/execute register in place of the decoded control. This is used when a stall or a flush must insert a no-op.

The pipeline registers advance on every clock. The control pins are plain level signals with no handshake, because the datapath that shares these stage registers has no per-stage back-pressure. Control bits that the instruction does not need are driven to 0.

Top module: `ctrl_pipe_top`

## Requirements
- R1: While rst_n is low, all six control outputs are zero. They stay zero until the first clock edge after reset is released.
- R2: Output field layout. The execute group is {dst_sel_rd, alu_mode[1:0], opb_imm}, with dst_sel_rd as the top bit. The memory group is {br_en, rd_en, wr_en}. The write-back group is {rf_we, load_sel}. An R-type opcode 000000 decodes to execute 4'b1100, memory 3'b000 and write-back 2'b10.
- R3: A load opcode 100011 decodes to execute 4'b0001, memory 3'b010 and write-back 2'b11.
- R4: A store opcode 101011 decodes to execute 4'b0001, memory 3'b001 and write-back 2'b00. The bits whose value does not matter are driven to 0.
- R5: A branch-if-equal opcode 000100 decodes to execute 4'b0010, memory 3'b100 and write-back 2'b00. The bits whose value does not matter are driven to 0.
- R6: Any other opcode decodes to all-zero control in every group.
- R7: When bubble is high at a clock edge, all three groups written into the decode/execute register are zero, whatever the opcode.
- R8: The decoded groups appear at the decode/execute outputs one edge after the opcode is presented. The memory group and write-back group appear at execute/memory one edge later. The write-back group appears at memory/write-back one edge after that.
- R9: Consecutive different opcodes never mix. Each stage output shows only the control of the instruction that currently occupies that stage.
- R10: No stage ever holds more than one of br_en, rd_en and wr_en set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 6 | Opcode of the instruction in decode |
| bubble | input | 1 | Load a zero control word into decode/execute |
| idex_ex | output | 4 | Execute group at decode/execute |
| idex_mem | output | 3 | Memory group at decode/execute |
| idex_wb | output | 2 | Write-back group at decode/execute |
| exmem_mem | output | 3 | Memory group at execute/memory |
| exmem_wb | output | 2 | Write-back group at execute/memory |
| memwb_wb | output | 2 | Write-back group at memory/write-back |

## Verification
Each opcode class is first sent alone, with idle opcodes before and after it. This shows its decoded word and confirms that the word lands in each later stage exactly one edge apart. A back-to-back mix of R-type, load, store and branch then puts four different words in flight at once, which would expose a group shifted into the wrong stage. Unknown opcodes and bubbles asserted over valid opcodes show whether the zero word comes from the decoder or from the bubble path.

// File: rtl/ctrl_pipe_pkg.sv
package ctrl_pipe_pkg;

  localparam int OPC_W = 6;

  typedef struct packed {
    logic       dst_sel_rd;
    logic [1:0] alu_mode;
    logic       opb_imm;
  } ex_grp_t;

  typedef struct packed {
    logic br_en;
    logic rd_en;
    logic wr_en;
  } mem_grp_t;

  typedef struct packed {
    logic rf_we;
    logic load_sel;
  } wb_grp_t;

  localparam int EX_W  = $bits(ex_grp_t);
  localparam int MEM_W = $bits(mem_grp_t);
  localparam int WB_W  = $bits(wb_grp_t);

  localparam logic [1:0] ALU_ADD  = 2'b00;
  localparam logic [1:0] ALU_SUB  = 2'b01;
  localparam logic [1:0] ALU_FUNC = 2'b10;

endpackage

// File: rtl/ctrl_word_decode.sv
module ctrl_word_decode
  import ctrl_pipe_pkg::*;
#(
  parameter logic [OPC_W-1:0] OP_RTYPE = 6'b000000,
  parameter logic [OPC_W-1:0] OP_LOAD  = 6'b100011,
  parameter logic [OPC_W-1:0] OP_STORE = 6'b101011,
  parameter logic [OPC_W-1:0] OP_BEQ   = 6'b000100
) (
  input  logic [OPC_W-1:0] opcode,
  output ex_grp_t          ex_o,
  output mem_grp_t         mem_o,
  output wb_grp_t          wb_o
);

  always_comb begin
    ex_o  = '0;
    mem_o = '0;
    wb_o  = '0;
    unique case (opcode)
      OP_RTYPE: begin
        ex_o.dst_sel_rd = 1'b1;
        ex_o.alu_mode   = ALU_FUNC;
        wb_o.rf_we      = 1'b1;
      end
      OP_LOAD: begin
        ex_o.alu_mode   = ALU_ADD;
        ex_o.opb_imm    = 1'b1;
        mem_o.rd_en     = 1'b1;
        wb_o.rf_we      = 1'b1;
        wb_o.load_sel   = 1'b1;
      end
      OP_STORE: begin
        ex_o.alu_mode   = ALU_ADD;
        ex_o.opb_imm    = 1'b1;
        mem_o.wr_en     = 1'b1;
      end
      OP_BEQ: begin
        ex_o.alu_mode   = ALU_SUB;
        mem_o.br_en     = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/ctrl_stage_reg.sv
module ctrl_stage_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (clr) q <= '0;
    else          q <= d;
  end

endmodule

// File: rtl/ctrl_pipe_top.sv
module ctrl_pipe_top
  import ctrl_pipe_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPC_W-1:0] opcode,
  input  logic             bubble,
  output logic [EX_W-1:0]  idex_ex,
  output logic [MEM_W-1:0] idex_mem,
  output logic [WB_W-1:0]  idex_wb,
  output logic [MEM_W-1:0] exmem_mem,
  output logic [WB_W-1:0]  exmem_wb,
  output logic [WB_W-1:0]  memwb_wb
);

  localparam int IDEX_W  = EX_W + MEM_W + WB_W;
  localparam int EXMEM_W = MEM_W + WB_W;

  ex_grp_t  dec_ex;
  mem_grp_t dec_mem;
  wb_grp_t  dec_wb;

  logic [IDEX_W-1:0]  idex_q;
  logic [EXMEM_W-1:0] exmem_q;
  logic [WB_W-1:0]    memwb_q;

  ctrl_word_decode u_dec (
    .opcode (opcode),
    .ex_o   (dec_ex),
    .mem_o  (dec_mem),
    .wb_o   (dec_wb)
  );

  // decode/execute: bubble clears the word on its way in
  ctrl_stage_reg #(.W(IDEX_W)) u_idex (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (bubble),
    .d     ({dec_ex, dec_mem, dec_wb}),
    .q     (idex_q)
  );

  // execute/memory: execute group retired, rest carried
  ctrl_stage_reg #(.W(EXMEM_W)) u_exmem (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (1'b0),
    .d     (idex_q[EXMEM_W-1:0]),
    .q     (exmem_q)
  );

  // memory/write-back: only the write-back group survives
  ctrl_stage_reg #(.W(WB_W)) u_memwb (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (1'b0),
    .d     (exmem_q[WB_W-1:0]),
    .q     (memwb_q)
  );

  assign idex_ex   = idex_q[IDEX_W-1 -: EX_W];
  assign idex_mem  = idex_q[EXMEM_W-1 -: MEM_W];
  assign idex_wb   = idex_q[WB_W-1:0];
  assign exmem_mem = exmem_q[EXMEM_W-1 -: MEM_W];
  assign exmem_wb  = exmem_q[WB_W-1:0];
  assign memwb_wb  = memwb_q;

  a_r7_bubble_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bubble |=> (idex_ex == '0 && idex_mem == '0 && idex_wb == '0));

  a_r8_mem_advance: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (exmem_mem == $past(idex_mem) && exmem_wb == $past(idex_wb)));

  a_r8_wb_advance: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (memwb_wb == $past(exmem_wb)));

  a_r10_one_mem_op: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(idex_mem) && $onehot0(exmem_mem));

  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |-> (idex_q == '0 && exmem_q == '0 && memwb_q == '0));

endmodule

// File: tb/test_ctrl_pipe_top.sv
`timescale 1ns/1ps
module test_ctrl_pipe_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] opcode = 6'b111111;
  logic       bubble = 1'b0;
  logic [3:0] idex_ex;
  logic [2:0] idex_mem, exmem_mem;
  logic [1:0] idex_wb, exmem_wb, memwb_wb;

  int n_cmp = 0;
  int n_bad = 0;

  logic [8:0] e_idex  = '0;
  logic [4:0] e_exmem = '0;
  logic [1:0] e_memwb = '0;

  always #10 clk = ~clk;

  ctrl_pipe_top i_ctrl_pipe_top (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .bubble(bubble),
    .idex_ex(idex_ex), .idex_mem(idex_mem), .idex_wb(idex_wb),
    .exmem_mem(exmem_mem), .exmem_wb(exmem_wb), .memwb_wb(memwb_wb)
  );

  function automatic logic [8:0] want(input logic [5:0] op);
    case (op)
      6'b000000: want = {4'b1100, 3'b000, 2'b10};
      6'b100011: want = {4'b0001, 3'b010, 2'b11};
      6'b101011: want = {4'b0001, 3'b001, 2'b00};
      6'b000100: want = {4'b0010, 3'b100, 2'b00};
      default:   want = '0;
    endcase
  endfunction

  task automatic check(input string tag);
    logic [17:0] act, exp;
    act = {idex_ex, idex_mem, idex_wb, exmem_mem, exmem_wb, memwb_wb};
    exp = {e_idex, e_exmem, e_memwb};
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // drive one opcode, clock it, then check every stage 5 ns after the edge
  task automatic step(input logic [5:0] op, input logic bub, input string tag);
    opcode = op;
    bubble = bub;
    @(posedge clk);
    e_memwb = e_exmem[1:0];
    e_exmem = e_idex[4:0];
    e_idex  = bub ? 9'd0 : want(op);
    #5;
    check(tag);
  endtask

  task automatic t_reset;
    #15;
    check("R1 during reset");
    @(negedge clk);
    rst_n = 1'b1;
    #5;
    check("R1 after release");
  endtask

  task automatic t_single(input logic [5:0] op, input string tag);
    step(op, 1'b0, tag);
    for (int i = 0; i < 3; i++) step(6'b111111, 1'b0, {tag, " R8 drain"});
  endtask

  task automatic t_mix;
    step(6'b000000, 1'b0, "R9 mix r-type");
    step(6'b100011, 1'b0, "R9 mix load");
    step(6'b101011, 1'b0, "R9 mix store");
    step(6'b000100, 1'b0, "R9 R10 mix branch");
    step(6'b100011, 1'b0, "R9 mix load2");
    step(6'b000000, 1'b0, "R9 mix r-type2");
  endtask

  task automatic t_unknown;
    step(6'b100011, 1'b0, "R6 prefill");
    step(6'b000001, 1'b0, "R6 op 000001");
    step(6'b101111, 1'b0, "R6 op 101111");
    step(6'b100010, 1'b0, "R6 op 100010");
  endtask

  task automatic t_bubble;
    step(6'b000000, 1'b1, "R7 bubble r-type");
    step(6'b100011, 1'b1, "R7 bubble load");
    step(6'b101011, 1'b0, "R7 after bubble");
    step(6'b000100, 1'b1, "R7 bubble branch");
    step(6'b111111, 1'b0, "R7 drain");
    step(6'b111111, 1'b0, "R7 drain2");
  endtask

  initial begin
    t_reset();
    t_single(6'b000000, "R2 R8 r-type");
    t_single(6'b100011, "R3 R8 load");
    t_single(6'b101011, "R4 R8 store");
    t_single(6'b000100, "R5 R8 branch");
    t_mix();
    t_unknown();
    t_bubble();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule